// File: doc/BRIEF.md
# Row/Column Multiplexed Programming Port

This block is the front end of a parallel programming port. A programmer with few pins presents a 19-bit byte address as two halves on one 11-bit address bus. A falling edge of the row/column strobe captures the low half and a rising edge of the same strobe captures the high half. Bytes and commands arrive on an 8-bit data bus and are taken on the trailing (rising) edge of an active-low write enable. Each accepted write becomes a single one-cycle request to the internal memory core. Read data from the core is driven back under an active-low output enable.

Every strobe is asynchronous to the internal clock. Each one passes through a two-flop synchronizer before its edges are detected. A ready/busy output mirrors the ready bit of the core's status byte. While the core reports busy, write strobes are dropped. An interface-select input chooses this port (high) or the serial bus port (low). It is only sampled while reset is held, so the choice stays fixed during operation.

Top module: `amux_prog_port`

## Requirements
- R1: A falling edge of `rc_strobe_i` loads `addr_o[10:0]` from `addr_pins_i[10:0]` and leaves `addr_o[18:11]` unchanged.
- R2: A rising edge of `rc_strobe_i` loads `addr_o[18:11]` from `addr_pins_i[7:0]` and leaves `addr_o[10:0]` unchanged.
- R3: Each rising edge of `we_n_i` on a ready core gives exactly one single-cycle pulse on `wr_req_o`, with `wr_data_o` equal to the byte on `data_i` at that edge.
- R4: While `oe_n_i` is high, `data_oe_o` is 0. While it is low, `data_oe_o` is 1 and `data_o` carries the core byte `rd_data_i` returned for the current address, fetched by one `rd_req_o` pulse per falling edge of `oe_n_i`.
- R5: `rdy_bsy_o` equals `core_status_i[7]` of the previous clock cycle (1 = ready, 0 = busy), and it is 1 during reset.
- R6: While `core_status_i[7]` is 0 (busy), a write strobe produces no `wr_req_o` pulse and leaves `wr_data_o` unchanged.
- R7: While `rst_n` is low, no write request is issued, `addr_o` is cleared to zero, `data_oe_o` is 0 and strobe activity is ignored. After release, the port reads the array with no command needed.
- R8: `if_sel_i` is sampled only while `rst_n` is low, and `port_sel_o` shows the sampled value. If it was 0, the port issues no requests and never drives data, and changing `if_sel_i` after reset has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Synchronous active-low reset |
| if_sel_i | input | 1 | Interface select, 1 = this port, sampled during reset |
| addr_pins_i | input | 11 | Multiplexed address bus |
| rc_strobe_i | input | 1 | Row/column strobe: fall = low half, rise = high half |
| we_n_i | input | 1 | Write enable, active low, data taken on rising edge |
| oe_n_i | input | 1 | Output enable, active low |
| data_i | input | 8 | Data bus, incoming direction |
| data_o | output | 8 | Data bus, outgoing direction |
| data_oe_o | output | 1 | Data bus driver enable |
| rdy_bsy_o | output | 1 | Ready (1) / busy (0) |
| port_sel_o | output | 1 | Interface choice frozen at reset |
| addr_o | output | 19 | Assembled byte address to the core |
| wr_req_o | output | 1 | One-cycle write request to the core |
| wr_data_o | output | 8 | Write byte to the core |
| rd_req_o | output | 1 | One-cycle read request to the core |
| rd_data_i | input | 8 | Read byte from the core |
| core_status_i | input | 8 | Core status byte, bit 7 = ready |

## Verification
The bench drives address pairs whose row and column halves differ in every bit. A design that swapped the strobe edges, or that cleared the other half on a load, would therefore give a wrong `addr_o`. It counts request pulses over whole strobe windows. A write path that acted on a level instead of an edge would repeat requests, and one that ignored the busy bit would issue a request while busy. Strobes toggled during reset, and `if_sel_i` changed after reset, expose a design that lets either of them through.

// File: rtl/amux_pkg.sv
// Package: shared sizing for the multiplexed programming port.
// Assumes the column half is no wider than the address pin bus.
package amux_pkg;
    localparam int PIN_W     = 11;
    localparam int COL_W     = 8;
    localparam int DATA_W    = 8;
    localparam int READY_BIT = 7;
    localparam int STB_N     = 3;
    localparam int STB_RC    = 0;
    localparam int STB_WE    = 1;
    localparam int STB_OE    = 2;
endpackage

// File: rtl/amux_strobe_sync.sv
// Module: two-flop synchronizer plus edge detector for N strobes.
// Assumes strobes are slow compared to clk; idle level given by IDLE.
module amux_strobe_sync #(
    parameter int         N    = 3,
    parameter logic [N-1:0] IDLE = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        logic s1, s2, s3;
        // Purpose: metastability stages and edge history register.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1 <= IDLE[g];
                s2 <= IDLE[g];
                s3 <= IDLE[g];
            end else begin
                s1 <= raw_i[g];
                s2 <= s1;
                s3 <= s2;
            end
        end
        assign lvl_o[g]  = s2;
        assign rise_o[g] = s2 & ~s3;
        assign fall_o[g] = ~s2 & s3;
    end
endmodule

// File: rtl/amux_addr_latch.sv
// Module: assembles the full address from two strobe phases.
// Assumes the pins are stable through the synchronizer delay around an edge.
module amux_addr_latch #(
    parameter int PIN_W = 11,
    parameter int COL_W = 8,
    localparam int ADDR_W = PIN_W + COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              row_stb_i,
    input  logic              col_stb_i,
    input  logic [PIN_W-1:0]  pins_i,
    output logic [ADDR_W-1:0] addr_o
);
    // Purpose: load the low half on the row phase, the high half on the column phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_o <= '0;
        end else if (en_i) begin
            if (row_stb_i) addr_o[PIN_W-1:0]      <= pins_i;
            if (col_stb_i) addr_o[ADDR_W-1:PIN_W] <= pins_i[COL_W-1:0];
        end
    end
endmodule

// File: rtl/amux_write_path.sv
// Module: captures a write byte and raises one request per accepted strobe.
// Assumes data is stable at the synchronized write edge; busy drops the strobe.
module amux_write_path #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              we_edge_i,
    input  logic              ready_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              wr_req_o,
    output logic [DATA_W-1:0] wr_data_o
);
    logic accept;
    assign accept = en_i & we_edge_i & ready_i;

    // Purpose: one-cycle request pulse and held write byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_req_o  <= 1'b0;
            wr_data_o <= '0;
        end else begin
            wr_req_o <= accept;
            if (accept) wr_data_o <= data_i;
        end
    end
endmodule

// File: rtl/amux_read_path.sv
// Module: fetches a core byte on output-enable assertion and drives it.
// Assumes the core answers in the cycle after the read request.
module amux_read_path #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              oe_n_lvl_i,
    input  logic              oe_fall_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              rd_req_o,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe_o
);
    logic pend_q;

    // Purpose: request pulse, then capture of the returned byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_req_o <= 1'b0;
            pend_q   <= 1'b0;
            data_o   <= '0;
        end else begin
            rd_req_o <= en_i & oe_fall_i;
            pend_q   <= rd_req_o;
            if (pend_q) data_o <= rd_data_i;
        end
    end

    assign data_oe_o = en_i & ~oe_n_lvl_i;
endmodule

// File: rtl/amux_prog_port.sv
// Module: top of the row/column multiplexed programming port.
// Assumes asynchronous strobes and a core that reports ready on a status bit.
module amux_prog_port #(
    parameter int PIN_W     = amux_pkg::PIN_W,
    parameter int COL_W     = amux_pkg::COL_W,
    parameter int DATA_W    = amux_pkg::DATA_W,
    parameter int READY_BIT = amux_pkg::READY_BIT,
    localparam int ADDR_W   = PIN_W + COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              if_sel_i,
    input  logic [PIN_W-1:0]  addr_pins_i,
    input  logic              rc_strobe_i,
    input  logic              we_n_i,
    input  logic              oe_n_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe_o,
    output logic              rdy_bsy_o,
    output logic              port_sel_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              wr_req_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              rd_req_o,
    input  logic [DATA_W-1:0] rd_data_i,
    input  logic [DATA_W-1:0] core_status_i
);
    import amux_pkg::*;

    logic              sel_q;
    logic              rdy_q;
    logic [STB_N-1:0]  raw, lvl, rise, fall;

    // Purpose: freeze the interface choice while reset is asserted.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= if_sel_i;
    end

    // Purpose: registered mirror of the core ready bit.
    always_ff @(posedge clk) begin
        if (!rst_n) rdy_q <= 1'b1;
        else        rdy_q <= core_status_i[READY_BIT];
    end

    assign raw[STB_RC] = rc_strobe_i;
    assign raw[STB_WE] = we_n_i;
    assign raw[STB_OE] = oe_n_i;

    amux_strobe_sync #(.N(STB_N), .IDLE('1)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (raw),
        .lvl_o  (lvl),
        .rise_o (rise),
        .fall_o (fall)
    );

    amux_addr_latch #(.PIN_W(PIN_W), .COL_W(COL_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (sel_q),
        .row_stb_i (fall[STB_RC]),
        .col_stb_i (rise[STB_RC]),
        .pins_i    (addr_pins_i),
        .addr_o    (addr_o)
    );

    amux_write_path #(.DATA_W(DATA_W)) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (sel_q),
        .we_edge_i (rise[STB_WE]),
        .ready_i   (core_status_i[READY_BIT]),
        .data_i    (data_i),
        .wr_req_o  (wr_req_o),
        .wr_data_o (wr_data_o)
    );

    amux_read_path #(.DATA_W(DATA_W)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (sel_q),
        .oe_n_lvl_i (lvl[STB_OE]),
        .oe_fall_i  (fall[STB_OE]),
        .rd_data_i  (rd_data_i),
        .rd_req_o   (rd_req_o),
        .data_o     (data_o),
        .data_oe_o  (data_oe_o)
    );

    assign rdy_bsy_o  = rdy_q;
    assign port_sel_o = sel_q;
endmodule

// File: rtl/amux_prog_port_chk.sv
// Module: assertion checker bound to the programming port top.
module amux_prog_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_req_o,
    input logic        rd_req_o,
    input logic        data_oe_o,
    input logic        port_sel_o,
    input logic        rdy_bsy_o,
    input logic [7:0]  core_status_i
);
    // R3
    wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o |=> !wr_req_o);
    // R6
    wr_only_when_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o |-> $past(core_status_i[7]));
    // R8
    sel_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(port_sel_o));
    // R8
    unselected_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !port_sel_o |-> (!wr_req_o && !rd_req_o && !data_oe_o));
    // R5
    ready_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rdy_bsy_o == $past(core_status_i[7])));
    // R7
    reset_blocks_write_chk: assert property (@(posedge clk)
        !rst_n |=> (!wr_req_o && !data_oe_o));
endmodule

bind amux_prog_port amux_prog_port_chk chk_i (.*);

// File: tb/amux_prog_port_tb_top.sv
module amux_prog_port_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        if_sel_i = 1'b1;
    logic [10:0] addr_pins_i = '0;
    logic        rc_strobe_i = 1'b1;
    logic        we_n_i = 1'b1;
    logic        oe_n_i = 1'b1;
    logic [7:0]  data_i = '0;
    logic [7:0]  data_o;
    logic        data_oe_o;
    logic        rdy_bsy_o;
    logic        port_sel_o;
    logic [18:0] addr_o;
    logic        wr_req_o;
    logic [7:0]  wr_data_o;
    logic        rd_req_o;
    logic [7:0]  rd_data_i;
    logic [7:0]  core_status_i = 8'h80;

    int errors = 0;
    int checks = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Core model: read byte derived from the address.
    assign rd_data_i = addr_o[7:0] ^ 8'hA5;

    amux_prog_port dut_i (.*);

    always @(posedge clk) begin
        if (wr_req_o) wr_cnt++;
        if (rd_req_o) rd_cnt++;
    end

    // Vectors: {row[10:0], column[7:0], write byte[7:0]}
    localparam logic [26:0] VECS [4] = '{
        {11'h7FF, 8'h00, 8'h3C},
        {11'h000, 8'hFF, 8'hC3},
        {11'h555, 8'hAA, 8'h96},
        {11'h2A1, 8'h5E, 8'h01}
    };

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic send_addr(input logic [10:0] row, input logic [7:0] col);
        addr_pins_i = row; rc_strobe_i = 1'b0; wait_n(6);
        addr_pins_i = {3'b000, col}; rc_strobe_i = 1'b1; wait_n(6);
    endtask

    task automatic strobe_we(input logic [7:0] b);
        data_i = b; we_n_i = 1'b0; wait_n(5);
        we_n_i = 1'b1; wait_n(6);
    endtask

    task automatic do_reset(input logic sel);
        @(negedge clk); if_sel_i = sel; rst_n = 1'b0; wait_n(4);
        rst_n = 1'b1; wait_n(2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [18:0] exp_addr;
        logic [7:0]  prev_wd;
        // Reset state (R7, R5, R8)
        wait_n(3);
        check(addr_o == 19'h0, "R7 addr in reset", addr_o, 0);
        check(data_oe_o == 1'b0, "R7 oe in reset", data_oe_o, 0);
        check(rdy_bsy_o == 1'b1, "R5 ready in reset", rdy_bsy_o, 1);
        rst_n = 1'b1; wait_n(2);
        check(port_sel_o == 1'b1, "R8 sel sampled high", port_sel_o, 1);

        // Table walk: R1, R2, R3
        for (int i = 0; i < 4; i++) begin
            logic [10:0] row; logic [7:0] col, b;
            {row, col, b} = VECS[i];
            exp_addr = addr_o;
            addr_pins_i = row; rc_strobe_i = 1'b0; wait_n(6);
            exp_addr[10:0] = row;
            check(addr_o == exp_addr, "R1 row phase", addr_o, exp_addr);
            addr_pins_i = {~3'b000, col}; rc_strobe_i = 1'b1; wait_n(6);
            exp_addr[18:11] = col;
            check(addr_o == exp_addr, "R2 column phase", addr_o, exp_addr);
            wr_cnt = 0;
            strobe_we(b);
            check(wr_cnt == 1, "R3 one request", wr_cnt, 1);
            check(wr_data_o == b, "R3 write byte", wr_data_o, b);
        end

        // R4: read under output enable
        send_addr(11'h012, 8'h34);
        check(data_oe_o == 1'b0, "R4 tristate when oe high", data_oe_o, 0);
        rd_cnt = 0;
        oe_n_i = 1'b0; wait_n(8);
        check(data_oe_o == 1'b1, "R4 driving when oe low", data_oe_o, 1);
        check(data_o == (8'h12 ^ 8'hA5), "R4 read byte", data_o, 8'h12 ^ 8'hA5);
        check(rd_cnt == 1, "R4 one read request", rd_cnt, 1);
        oe_n_i = 1'b1; wait_n(5);
        check(data_oe_o == 1'b0, "R4 released", data_oe_o, 0);

        // R5 and R6: busy core
        prev_wd = wr_data_o;
        core_status_i = 8'h7F; wait_n(2);
        check(rdy_bsy_o == 1'b0, "R5 busy mirrored", rdy_bsy_o, 0);
        wr_cnt = 0;
        strobe_we(8'hEE);
        check(wr_cnt == 0, "R6 no request when busy", wr_cnt, 0);
        check(wr_data_o == prev_wd, "R6 byte kept", wr_data_o, prev_wd);
        core_status_i = 8'h80; wait_n(2);
        check(rdy_bsy_o == 1'b1, "R5 ready mirrored", rdy_bsy_o, 1);

        // R7: strobes during reset are ignored; read works after release
        @(negedge clk); rst_n = 1'b0; wr_cnt = 0;
        addr_pins_i = 11'h3FF; rc_strobe_i = 1'b0; data_i = 8'h77; we_n_i = 1'b0; wait_n(5);
        rc_strobe_i = 1'b1; we_n_i = 1'b1; wait_n(5);
        check(wr_cnt == 0, "R7 write blocked in reset", wr_cnt, 0);
        check(addr_o == 19'h0, "R7 addr cleared", addr_o, 0);
        rst_n = 1'b1; wait_n(2);
        send_addr(11'h0C8, 8'h01);
        oe_n_i = 1'b0; wait_n(8);
        check(data_o == (8'hC8 ^ 8'hA5), "R7 read after reset", data_o, 8'hC8 ^ 8'hA5);
        oe_n_i = 1'b1; wait_n(5);

        // R8: unselected port stays quiet, later select change ignored
        do_reset(1'b0);
        if_sel_i = 1'b1; wait_n(2);
        check(port_sel_o == 1'b0, "R8 sel frozen low", port_sel_o, 0);
        wr_cnt = 0; rd_cnt = 0;
        strobe_we(8'h42);
        oe_n_i = 1'b0; wait_n(8);
        check(wr_cnt == 0, "R8 no write when unselected", wr_cnt, 0);
        check(rd_cnt == 0, "R8 no read when unselected", rd_cnt, 0);
        check(data_oe_o == 1'b0, "R8 no drive when unselected", data_oe_o, 0);
        oe_n_i = 1'b1; wait_n(5);
        do_reset(1'b1);
        check(port_sel_o == 1'b1, "R8 reselected by reset", port_sel_o, 1);

        finish_run();
    end
endmodule